// File: doc/BRIEF.md
# DMA Address Translation Unit

This block sits between a DMA-capable device and host memory and turns each device address into a host physical address. The device address is split into a 4 KB page offset and an I/O page number. The page number indexes a flat table of 64-bit translation entries held in host memory. Each entry supplies a real page number and separate read and write permission bits. The unit either returns the host address or reports a fault.

An eight-way, fully associative translation cache keeps recently fetched entries, so a repeated page is answered without touching memory. The cache can only be emptied as a whole by a flush command. That command is accepted only while no translation is in progress. While a flush is pending, new requests are refused.

The unit handles one translation at a time. Every channel uses a valid/ready handshake: the request, the response, the entry-fetch read and the flush command.

Top module: `dma_xlate`

## Requirements
- R1: For a permitted access, the response address is the entry's real page number placed above the unchanged low 12 bits of the request address.
- R2: A cache miss issues one memory read at address TABLE_BASE + page × 8, where the page is the request address above bit 11. The read address is held steady until it is accepted.
- R3: In a fetched 64-bit entry, bit 0 (LSB numbering) grants read, bit 1 grants write and bits 47:12 are the 36-bit real page number. All other bits have no effect on the result.
- R4: An entry with both permission bits clear always gives a fault, for reads and for writes.
- R5: A read without the read bit, or a write without the write bit, faults. A faulting response carries address 0.
- R6: A page number of TABLE_LEN or above faults, and no memory read is made for it.
- R7: On a cache hit, the response is valid in the cycle after the request is accepted and no memory read is made. On a miss, the memory read is requested in the cycle after acceptance.
- R8: The cache holds 8 entries and replaces them in round-robin order, so the ninth distinct page fetched evicts the first one.
- R9: Changing a table entry in memory has no effect on a cached page until a flush. After the flush, the next access to that page fetches it again.
- R10: A flush is accepted only when no translation is in progress (flush_ready low otherwise). While flush_valid is high, req_ready is low.
- R11: A response stays valid, with a stable address and fault flag, until rsp_ready is seen.
- R12: After reset, no response or memory read is pending, the unit is ready for requests and flushes, and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Request accepted this cycle |
| req_addr | input | DADDR_W | Device DMA address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| rsp_valid | output | 1 | Translation result present |
| rsp_ready | input | 1 | Result consumed |
| rsp_addr | output | 48 | Host physical address (0 on fault) |
| rsp_fault | output | 1 | Access denied or invalid |
| mem_req_valid | output | 1 | Entry fetch read requested |
| mem_req_ready | input | 1 | Memory accepted the read |
| mem_req_addr | output | 48 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_ready | output | 1 | Unit waiting for read data |
| mem_rsp_data | input | 64 | Fetched translation entry |
| flush_valid | input | 1 | Flush-all command |
| flush_ready | output | 1 | Flush accepted this cycle |

## Verification
A stale or wrongly replaced cache line appears at the ports in one of two ways. A page that should miss shows up as a missing memory read. A page that should hit shows up as an unexpected one. The reference model tracks cache contents and flags either case in the cycle after the request is accepted. A wrongly decoded entry or a wrong permission check appears as a bad address or fault flag in the first response cycle. A flush that fails to clear the cache shows up on the next access to a remembered page, which returns old data without a memory read.

// File: rtl/dxu_pkg.sv
package dxu_pkg;

  localparam int PG_OFS_W  = 12;
  localparam int RPN_W     = 36;
  localparam int HUB_W     = 6;
  localparam int ENT_W     = 64;
  localparam int ENT_SHIFT = 3;
  localparam int HOST_W    = RPN_W + PG_OFS_W;

  // raw 64-bit table entry, LSB numbering
  typedef struct packed {
    logic [15:0]       rsv_hi;
    logic [RPN_W-1:0]  rpn;
    logic [3:0]        rsv_lo;
    logic [HUB_W-1:0]  hub;
    logic              wr_ok;
    logic              rd_ok;
  } xent_t;

  // portion of an entry kept in the translation cache
  typedef struct packed {
    logic [RPN_W-1:0]  rpn;
    logic              wr_ok;
    logic              rd_ok;
  } xcache_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_RESP
  } xst_t;

  function automatic xcache_t squeeze_entry(input xent_t e);
    xcache_t c;
    c.rpn   = e.rpn;
    c.wr_ok = e.wr_ok;
    c.rd_ok = e.rd_ok;
    return c;
  endfunction

  function automatic logic [HOST_W-1:0] entry_addr(input logic [HOST_W-1:0] base,
                                                   input logic [HOST_W-1:0] page);
    return base + (page << ENT_SHIFT);
  endfunction

  function automatic logic access_allowed(input logic rd_ok, input logic wr_ok,
                                          input logic is_wr);
    return is_wr ? wr_ok : rd_ok;
  endfunction

  function automatic logic [HOST_W-1:0] join_host(input logic [RPN_W-1:0] rpn,
                                                  input logic [PG_OFS_W-1:0] ofs);
    return {rpn, ofs};
  endfunction

endpackage

// File: rtl/dxu_tcache.sv
module dxu_tcache #(
  parameter int WAYS   = 8,
  parameter int TAG_W  = 20,
  parameter int DATA_W = 38
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic [TAG_W-1:0]  look_tag,
  output logic              hit,
  output logic [DATA_W-1:0] hit_data,
  input  logic              fill_en,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [DATA_W-1:0] fill_data
);

  localparam int PTR_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam logic [PTR_W-1:0] LAST_WAY = PTR_W'(WAYS - 1);

  logic [PTR_W-1:0]  rr_ptr;
  logic [WAYS-1:0]   way_match;
  logic [DATA_W-1:0] way_data [WAYS];

  generate
    for (genvar i = 0; i < WAYS; i++) begin : g_way
      logic              v_q;
      logic [TAG_W-1:0]  tag_q;
      logic [DATA_W-1:0] dat_q;
      logic              pick;

      assign pick = fill_en && (rr_ptr == PTR_W'(i));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          v_q   <= 1'b0;
          tag_q <= '0;
          dat_q <= '0;
        end else if (flush) begin
          v_q   <= 1'b0;
        end else if (pick) begin
          v_q   <= 1'b1;
          tag_q <= fill_tag;
          dat_q <= fill_data;
        end
      end

      assign way_match[i] = v_q && (tag_q == look_tag);
      assign way_data[i]  = dat_q;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_ptr <= '0;
    end else if (flush) begin
      rr_ptr <= '0;
    end else if (fill_en) begin
      rr_ptr <= (rr_ptr == LAST_WAY) ? '0 : rr_ptr + 1'b1;
    end
  end

  assign hit = |way_match;

  always_comb begin
    hit_data = '0;
    for (int k = 0; k < WAYS; k++) begin
      if (way_match[k]) hit_data = hit_data | way_data[k];
    end
  end

endmodule

// File: rtl/dxu_perm.sv
module dxu_perm import dxu_pkg::*; (
  input  logic [RPN_W-1:0]    rpn,
  input  logic                rd_ok,
  input  logic                wr_ok,
  input  logic                is_wr,
  input  logic                in_range,
  input  logic [PG_OFS_W-1:0] ofs,
  output logic                fault,
  output logic [HOST_W-1:0]   haddr
);

  logic ent_invalid;
  logic granted;

  assign ent_invalid = !rd_ok && !wr_ok;
  assign granted     = access_allowed(rd_ok, wr_ok, is_wr);
  assign fault       = !in_range || ent_invalid || !granted;
  assign haddr       = fault ? '0 : join_host(rpn, ofs);

endmodule

// File: rtl/dma_xlate.sv
module dma_xlate import dxu_pkg::*; #(
  parameter int                DADDR_W    = 32,
  parameter int                TABLE_LEN  = 1024,
  parameter logic [HOST_W-1:0] TABLE_BASE = 48'h0000_8000_0000,
  parameter int                WAYS       = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [DADDR_W-1:0] req_addr,
  input  logic               req_write,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [HOST_W-1:0]  rsp_addr,
  output logic               rsp_fault,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [HOST_W-1:0]  mem_req_addr,
  input  logic               mem_rsp_valid,
  output logic               mem_rsp_ready,
  input  logic [ENT_W-1:0]   mem_rsp_data,
  input  logic               flush_valid,
  output logic               flush_ready
);

  localparam int IOPN_W = DADDR_W - PG_OFS_W;
  localparam logic [IOPN_W:0] LEN_L = (IOPN_W + 1)'(TABLE_LEN);
  localparam int CDAT_W = $bits(xcache_t);

  xst_t state;

  logic [IOPN_W-1:0]   cur_page;
  logic [PG_OFS_W-1:0] cur_ofs;
  logic                cur_wr;
  logic [HOST_W-1:0]   rsp_addr_q;
  logic                rsp_fault_q;

  // named events brought out for the checker
  logic idle;
  logic xlate_accept;
  logic miss_start;
  logic fill_evt;
  logic flush_evt;
  logic resp_done;

  logic [IOPN_W-1:0]   iopn_in;
  logic [PG_OFS_W-1:0] ofs_in;
  logic                in_range_in;

  logic              cache_hit;
  logic [CDAT_W-1:0] hit_raw;
  xcache_t           hit_ent;
  xent_t             fetched;
  xcache_t           fetched_c;
  logic              unused_fields;

  logic                sel_mem;
  xcache_t             pm_ent;
  logic                pm_wr;
  logic                pm_range;
  logic [PG_OFS_W-1:0] pm_ofs;
  logic                pm_fault;
  logic [HOST_W-1:0]   pm_haddr;

  assign iopn_in     = req_addr[DADDR_W-1:PG_OFS_W];
  assign ofs_in      = req_addr[PG_OFS_W-1:0];
  assign in_range_in = {1'b0, iopn_in} < LEN_L;

  assign idle         = (state == ST_IDLE);
  assign flush_ready  = idle;
  assign flush_evt    = flush_valid && idle;
  assign req_ready    = idle && !flush_valid;
  assign xlate_accept = req_valid && req_ready;
  assign miss_start   = xlate_accept && in_range_in && !cache_hit;
  assign fill_evt     = (state == ST_WAIT) && mem_rsp_valid;
  assign resp_done    = rsp_valid && rsp_ready;

  assign fetched       = xent_t'(mem_rsp_data);
  assign fetched_c     = squeeze_entry(fetched);
  assign unused_fields = ^{fetched.rsv_hi, fetched.rsv_lo, fetched.hub};
  assign hit_ent       = xcache_t'(hit_raw);

  dxu_tcache #(
    .WAYS   (WAYS),
    .TAG_W  (IOPN_W),
    .DATA_W (CDAT_W)
  ) u_tcache (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (flush_evt),
    .look_tag  (iopn_in),
    .hit       (cache_hit),
    .hit_data  (hit_raw),
    .fill_en   (fill_evt),
    .fill_tag  (cur_page),
    .fill_data (fetched_c)
  );

  // one shared check, fed either from the cache or from the fetched entry
  assign sel_mem  = (state == ST_WAIT);
  assign pm_ent   = sel_mem ? fetched_c : hit_ent;
  assign pm_wr    = sel_mem ? cur_wr    : req_write;
  assign pm_ofs   = sel_mem ? cur_ofs   : ofs_in;
  assign pm_range = sel_mem ? 1'b1      : in_range_in;

  dxu_perm u_perm (
    .rpn      (pm_ent.rpn),
    .rd_ok    (pm_ent.rd_ok),
    .wr_ok    (pm_ent.wr_ok),
    .is_wr    (pm_wr),
    .in_range (pm_range),
    .ofs      (pm_ofs),
    .fault    (pm_fault),
    .haddr    (pm_haddr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      cur_page    <= '0;
      cur_ofs     <= '0;
      cur_wr      <= 1'b0;
      rsp_addr_q  <= '0;
      rsp_fault_q <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          if (xlate_accept) begin
            cur_page <= iopn_in;
            cur_ofs  <= ofs_in;
            cur_wr   <= req_write;
            if (miss_start) begin
              state <= ST_FETCH;
            end else begin
              rsp_addr_q  <= pm_haddr;
              rsp_fault_q <= pm_fault;
              state       <= ST_RESP;
            end
          end
        end
        ST_FETCH: begin
          if (mem_req_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (fill_evt) begin
            rsp_addr_q  <= pm_haddr;
            rsp_fault_q <= pm_fault;
            state       <= ST_RESP;
          end
        end
        ST_RESP: begin
          if (resp_done) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign rsp_valid     = (state == ST_RESP);
  assign rsp_addr      = rsp_addr_q;
  assign rsp_fault     = rsp_fault_q;
  assign mem_req_valid = (state == ST_FETCH);
  assign mem_rsp_ready = (state == ST_WAIT);
  assign mem_req_addr  = entry_addr(TABLE_BASE, HOST_W'(cur_page));

endmodule

// File: rtl/dxu_chk.sv
module dxu_chk import dxu_pkg::*; #(
  parameter int                DADDR_W    = 32,
  parameter logic [HOST_W-1:0] TABLE_BASE = '0
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic [DADDR_W-1:0] req_addr,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [HOST_W-1:0]  rsp_addr,
  input logic               rsp_fault,
  input logic               mem_req_valid,
  input logic               mem_req_ready,
  input logic [HOST_W-1:0]  mem_req_addr,
  input logic               mem_rsp_ready,
  input logic [1:0]         perm_bits,
  input logic               flush_valid,
  input logic               flush_ready,
  input logic               xlate_accept,
  input logic               cache_hit,
  input logic               range_ok,
  input logic               fill_evt
);

  localparam int IOPN_W = DADDR_W - PG_OFS_W;

  logic [PG_OFS_W-1:0] ofs_seen;
  logic [IOPN_W-1:0]   page_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ofs_seen  <= '0;
      page_seen <= '0;
    end else if (xlate_accept) begin
      ofs_seen  <= req_addr[PG_OFS_W-1:0];
      page_seen <= req_addr[DADDR_W-1:PG_OFS_W];
    end
  end

  // R1
  offset_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_fault |-> rsp_addr[PG_OFS_W-1:0] == ofs_seen);

  // R2
  entry_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> mem_req_addr == TABLE_BASE + (HOST_W'(page_seen) << 3));

  // R2
  mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R4
  invalid_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_evt && (perm_bits == 2'b00) |=> rsp_valid && rsp_fault);

  // R5
  fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_addr == '0);

  // R6
  range_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xlate_accept && !range_ok |=> rsp_valid && rsp_fault && !mem_req_valid);

  // R7
  hit_fast_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xlate_accept && range_ok && cache_hit |=> rsp_valid && !mem_req_valid);

  // R7
  miss_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    xlate_accept && range_ok && !cache_hit |=> mem_req_valid);

  // R7
  single_flight_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rsp_valid, mem_req_valid, mem_rsp_ready}));

  // R10
  flush_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid && flush_ready |-> !rsp_valid && !mem_req_valid && !mem_rsp_ready);

  // R10
  flush_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |-> !req_ready);

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_addr) && $stable(rsp_fault));

endmodule

bind dma_xlate dxu_chk #(
  .DADDR_W    (DADDR_W),
  .TABLE_BASE (TABLE_BASE)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .req_addr      (req_addr),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_addr      (rsp_addr),
  .rsp_fault     (rsp_fault),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr),
  .mem_rsp_ready (mem_rsp_ready),
  .perm_bits     (mem_rsp_data[1:0]),
  .flush_valid   (flush_valid),
  .flush_ready   (flush_ready),
  .xlate_accept  (xlate_accept),
  .cache_hit     (cache_hit),
  .range_ok      (in_range_in),
  .fill_evt      (fill_evt)
);

// File: tb/dma_xlate_test.sv
`timescale 1ns/1ps
module dma_xlate_test;

  localparam logic [47:0] BASE = 48'h0000_8000_0000;
  localparam int LEN = 1024;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [47:0] rsp_addr;
  logic        rsp_fault;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [47:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic        mem_rsp_ready;
  logic [63:0] mem_rsp_data = '0;
  logic        flush_valid = 1'b0;
  logic        flush_ready;

  int total = 0;
  int bad = 0;
  int mem_reads = 0;
  int mon_bad = 0;
  bit fetch_ok = 0;
  bit done = 0;

  // behavioural model state
  logic [63:0] tbl   [int];
  logic [63:0] cdata [int];
  int          cq    [$];

  always #4 clk = ~clk;

  dma_xlate uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_addr(rsp_addr), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_ready(mem_rsp_ready), .mem_rsp_data(mem_rsp_data),
    .flush_valid(flush_valid), .flush_ready(flush_ready)
  );

  always @(posedge clk) if (mem_req_valid && mem_req_ready) mem_reads++;
  always @(negedge clk) if (rst_n && mem_req_valid && !fetch_ok) mon_bad++;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  function automatic logic [63:0] mem_entry(input int pg);
    logic [35:0] rpn;
    logic rd, wr;
    if (tbl.exists(pg)) return tbl[pg];
    rd  = (pg % 4 == 1) || (pg % 4 == 3);
    wr  = (pg % 4 >= 2);
    rpn = 36'h8_1234_0000 + 36'(pg * 7);
    return {16'hA5C3, rpn, 4'hE, 6'(pg), wr, rd};
  endfunction

  function automatic bit in_cache(input int pg);
    foreach (cq[i]) if (cq[i] == pg) return 1'b1;
    return 1'b0;
  endfunction

  task automatic model_flush();
    cq.delete();
    cdata.delete();
  endtask

  task automatic xlate(input int pg, input int ofs, input bit wr, input bit stall,
                       input bit flush_mid, input string tag);
    logic [63:0] ent;
    logic [47:0] exp_addr;
    logic [47:0] exp_maddr;
    bit rng, exp_mem, fault;
    int reads0;
    rng     = (pg < LEN);
    exp_mem = rng && !in_cache(pg);
    @(negedge clk);
    req_addr  = {20'(pg), 12'(ofs)};
    req_write = wr;
    req_valid = 1'b1;
    #1;
    chk(req_ready == 1'b1, {tag, " R10 request accepted when idle"}, 64'(req_ready), 64'd1);
    reads0   = mem_reads;
    fetch_ok = exp_mem;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (exp_mem) begin
      exp_maddr = BASE + 48'(pg) * 48'd8;
      chk(mem_req_valid == 1'b1, {tag, " R7 miss fetch next cycle"}, 64'(mem_req_valid), 64'd1);
      chk(mem_req_addr == exp_maddr, {tag, " R2 entry address"}, 64'(mem_req_addr), 64'(exp_maddr));
      if (flush_mid) begin
        flush_valid = 1'b1;
        #1;
        chk(flush_ready == 1'b0, {tag, " R10 flush waits while busy"}, 64'(flush_ready), 64'd0);
      end
      if (stall) begin
        @(posedge clk);
        @(negedge clk);
        chk(mem_req_valid && mem_req_addr == exp_maddr, {tag, " R2 read held"},
            64'(mem_req_addr), 64'(exp_maddr));
      end
      mem_req_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      mem_req_ready = 1'b0;
      chk(mem_rsp_ready == 1'b1, {tag, " R2 waiting for data"}, 64'(mem_rsp_ready), 64'd1);
      ent = mem_entry(pg);
      mem_rsp_data  = ent;
      mem_rsp_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      mem_rsp_data  = '0;
      if (cq.size() == 8) begin
        cdata.delete(cq[0]);
        void'(cq.pop_front());
      end
      cq.push_back(pg);
      cdata[pg] = ent;
    end else begin
      chk(mem_req_valid == 1'b0, {tag, " R6 R7 no fetch"}, 64'(mem_req_valid), 64'd0);
    end
    fetch_ok = 0;
    ent      = rng ? cdata[pg] : 64'd0;
    fault    = !rng || (wr ? !ent[1] : !ent[0]);
    exp_addr = fault ? 48'd0 : {ent[47:12], 12'(ofs)};
    chk(rsp_valid == 1'b1, {tag, " R7 response timing"}, 64'(rsp_valid), 64'd1);
    chk(rsp_fault == fault, {tag, " R4 R5 fault flag"}, 64'(rsp_fault), 64'(fault));
    chk(rsp_addr == exp_addr, {tag, " R1 R3 host address"}, 64'(rsp_addr), 64'(exp_addr));
    if (stall) begin
      @(posedge clk);
      @(negedge clk);
      chk(rsp_valid && rsp_addr == exp_addr && rsp_fault == fault, {tag, " R11 response held"},
          64'(rsp_addr), 64'(exp_addr));
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(rsp_valid == 1'b0, {tag, " R11 response retired"}, 64'(rsp_valid), 64'd0);
    chk(mem_reads - reads0 == (exp_mem ? 1 : 0), {tag, " R2 R6 memory read count"},
        64'(mem_reads - reads0), 64'(exp_mem));
    if (flush_mid) begin
      chk(flush_ready == 1'b1 && req_ready == 1'b0, {tag, " R10 flush now taken"},
          64'({flush_ready, req_ready}), 64'b10);
      @(posedge clk);
      @(negedge clk);
      flush_valid = 1'b0;
      model_flush();
    end
  endtask

  task automatic do_flush(input string tag);
    @(negedge clk);
    flush_valid = 1'b1;
    req_valid   = 1'b1;
    req_addr    = 32'h0000_3123;
    #1;
    chk(req_ready == 1'b0, {tag, " R10 request held off"}, 64'(req_ready), 64'd0);
    chk(flush_ready == 1'b1, {tag, " R10 flush accepted idle"}, 64'(flush_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    flush_valid = 1'b0;
    req_valid   = 1'b0;
    chk(!rsp_valid && !mem_req_valid, {tag, " R10 blocked request ignored"},
        64'({rsp_valid, mem_req_valid}), 64'd0);
    model_flush();
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL R12 watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int unsigned seed;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk(!rsp_valid && !mem_req_valid && !mem_rsp_ready, "R12 nothing pending",
        64'({rsp_valid, mem_req_valid, mem_rsp_ready}), 64'd0);
    chk(req_ready && flush_ready, "R12 ready after reset", 64'({req_ready, flush_ready}), 64'b11);

    // first access after reset misses (R12), read-only page
    xlate(5, 12'h3A4, 1'b0, 1'b1, 1'b0, "R12 R3 first read");
    xlate(5, 12'hFFF, 1'b0, 1'b0, 1'b0, "R7 hit read");
    xlate(5, 12'h001, 1'b1, 1'b0, 1'b0, "R5 write on read-only");
    xlate(4, 12'h010, 1'b0, 1'b0, 1'b0, "R4 invalid read");
    xlate(4, 12'h020, 1'b1, 1'b0, 1'b0, "R4 invalid write");
    xlate(6, 12'h800, 1'b1, 1'b0, 1'b0, "R5 write-only write");
    xlate(6, 12'h801, 1'b0, 1'b0, 1'b0, "R5 write-only read");
    xlate(7, 12'h555, 1'b1, 1'b1, 1'b0, "R1 rw write");
    xlate(7, 12'hAAA, 1'b0, 1'b0, 1'b0, "R1 rw read");
    xlate(LEN, 12'h000, 1'b0, 1'b0, 1'b0, "R6 first page past end");
    xlate(32'hFFFFF, 12'h123, 1'b1, 1'b0, 1'b0, "R6 top page");
    xlate(LEN - 1, 12'h0F0, 1'b0, 1'b0, 1'b0, "R6 last page in range");

    // stale entry stays until flush
    do_flush("R9 clean");
    xlate(7, 12'h111, 1'b0, 1'b0, 1'b0, "R9 load");
    tbl[7] = {16'h0, 36'h0_CAFE_0001, 4'h0, 6'h3F, 1'b1, 1'b1};
    xlate(7, 12'h222, 1'b0, 1'b0, 1'b0, "R9 stale hit");
    do_flush("R9 flush");
    xlate(7, 12'h333, 1'b0, 1'b0, 1'b0, "R9 refetch");

    // flush requested during a miss
    xlate(9, 12'h444, 1'b0, 1'b1, 1'b1, "R10 flush mid");
    xlate(9, 12'h445, 1'b0, 1'b0, 1'b0, "R10 after flush");

    // round-robin replacement
    do_flush("R8 clean");
    for (int p = 20; p < 29; p++) xlate(p, p * 16, 1'b0, 1'b0, 1'b0, "R8 fill");
    xlate(21, 12'h777, 1'b0, 1'b0, 1'b0, "R8 survivor hit");
    xlate(20, 12'h778, 1'b0, 1'b0, 1'b0, "R8 evicted miss");
    xlate(21, 12'h779, 1'b0, 1'b0, 1'b0, "R8 second victim");

    // mixed traffic
    seed = 32'h1234_5678;
    for (int i = 0; i < 40; i++) begin
      seed = seed * 32'd1103515245 + 32'd12345;
      xlate(int'((seed >> 16) % 12), int'(seed & 32'hFFF), seed[20], (i % 7) == 0, 1'b0,
            "R7 R8 mixed");
    end

    chk(mon_bad == 0, "R6 R7 unexpected memory read", 64'(mon_bad), 64'd0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule